// File: doc/BRIEF.md
# Atomic 64-bit compare-and-exchange unit

This unit performs an atomic compare-and-swap of one 64-bit memory location through a 32-bit request/acknowledge memory port. A single start pulse captures a byte address, an expected value and a replacement value. Each value is given as an upper half (bits 63:32) and a lower half (bits 31:0). The unit then holds a bus lock while it reads the two words of the location, compares them with the expected value and writes two words back.

On a match, the replacement value goes to memory and the zero flag is set. On a mismatch, the value just read is written back unchanged, the zero flag is cleared and the expected-value outputs take the value found in memory. A caller can then retry with those outputs directly. The write phase is issued in both cases, so every locked read is closed by a locked write and the lock is never dropped after a read alone.

Top module: `cas64_unit`

## Requirements
- R1: While rst_ni is low, and after it rises until the first start: busy_o, done_o, zf_o, mem_req_o and mem_lock_o are 0, and cmp_hi_o and cmp_lo_o are 0.
- R2: A start_i sampled high while idle captures addr_i, cmp_hi_i, cmp_lo_i, new_hi_i and new_lo_i. From the next cycle, busy_o is 1 and cmp_hi_o/cmp_lo_o show the captured expected value.
- R3: The bus performs exactly four beats in this order: a read at addr, a read at addr+4, a write at addr (lower word) and a write at addr+4 (upper word). mem_we_o is 1 only for the writes. Each beat holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o until mem_ack_i is sampled high at a rising edge.
- R4: mem_lock_o is 1 in every cycle from the first read request through the cycle of the last write acknowledge, and 0 otherwise. It is never released between the reads and the writes.
- R5: When the 64-bit memory value equals the expected value, zf_o becomes 1. The replacement lower and upper halves are written, and cmp_hi_o/cmp_lo_o keep the captured expected value.
- R6: When the values differ in any bit of either half, zf_o becomes 0. The read words are written back unchanged, and cmp_hi_o/cmp_lo_o take the memory value's upper and lower halves.
- R7: done_o is a one-cycle pulse in the first cycle after the last write acknowledge, with zf_o and cmp_hi_o/cmp_lo_o already final. If every acknowledge comes one cycle after its request first appears, done_o is high in the 10th cycle after the start edge.
- R8: Each cycle of acknowledge delay per beat adds one cycle to the latency: with w wait cycles per beat, done_o is high in cycle 4*(w+1)+2 after the start edge.
- R9: A start_i pulse while busy_o is 1 has no effect. Bus addresses, write data and results are those of the operation already running.
- R10: Between operations, zf_o, cmp_hi_o and cmp_lo_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| addr_i | input | ADDR_W | Byte address of the 8-byte location |
| cmp_hi_i | input | HALF_W | Expected value, bits 63:32 |
| cmp_lo_i | input | HALF_W | Expected value, bits 31:0 |
| new_hi_i | input | HALF_W | Replacement value, bits 63:32 |
| new_lo_i | input | HALF_W | Replacement value, bits 31:0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zf_o | output | 1 | Zero flag: 1 on match |
| cmp_hi_o | output | HALF_W | Updated expected value, bits 63:32 |
| cmp_lo_o | output | HALF_W | Updated expected value, bits 31:0 |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_wdata_o | output | HALF_W | Write data |
| mem_rdata_i | input | HALF_W | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_lock_o | output | 1 | Bus lock |

## Verification
On every cycle, the assertions check four things:
- a request is never made outside the lock;
- the lock falls only right after the upper-word write acknowledge;
- done is a single-cycle pulse that follows a write acknowledge;
- the flag and expected-value registers move only at completion, and carry the read value after a mismatch.

Only the bench scenarios can show the rest: the exact beat order and addresses, the written data for matching and mismatching halves, the cycle counts under different acknowledge delays, and that a start during an operation changes nothing.

// File: rtl/cas64_pkg.sv
package cas64_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_CMP,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN
  } cas_state_e;
endpackage

// File: rtl/cas64_ctrl.sv
module cas64_ctrl
  import cas64_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic req_o,
  output logic we_o,
  output logic hi_o,
  output logic lock_o,
  output logic busy_o,
  output logic done_o,
  output logic cap_o,
  output logic rd_lo_en_o,
  output logic rd_hi_en_o,
  output logic cmp_en_o,
  output logic fin_en_o
);
  cas_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RD_LO;
      ST_RD_LO: if (ack_i) state_d = ST_RD_HI;
      ST_RD_HI: if (ack_i) state_d = ST_CMP;
      ST_CMP:   state_d = ST_WR_LO;
      ST_WR_LO: if (ack_i) state_d = ST_WR_HI;
      ST_WR_HI: if (ack_i) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o      = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) ||
                      (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign we_o       = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign hi_o       = (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
  // lock also spans the compare cycle between read and write
  assign lock_o     = req_o || (state_q == ST_CMP);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign cap_o      = (state_q == ST_IDLE) && start_i;
  assign rd_lo_en_o = (state_q == ST_RD_LO) && ack_i;
  assign rd_hi_en_o = (state_q == ST_RD_HI) && ack_i;
  assign cmp_en_o   = (state_q == ST_CMP);
  assign fin_en_o   = (state_q == ST_WR_HI) && ack_i;

  // R4
  lock_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> lock_o);
  // R4
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(req_o && we_o && hi_o && ack_i));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(we_o && ack_i));
endmodule

// File: rtl/cas64_regs.sv
module cas64_regs #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              rd_lo_en_i,
  input  logic              rd_hi_en_i,
  input  logic              cmp_en_i,
  input  logic              fin_en_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] cmp_hi_i,
  input  logic [HALF_W-1:0] cmp_lo_i,
  input  logic [HALF_W-1:0] new_hi_i,
  input  logic [HALF_W-1:0] new_lo_i,
  input  logic [HALF_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [HALF_W-1:0] cmp_hi_o,
  output logic [HALF_W-1:0] cmp_lo_o,
  output logic [HALF_W-1:0] wr_hi_o,
  output logic [HALF_W-1:0] wr_lo_o,
  output logic              zf_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [HALF_W-1:0] cmp_hi_q, cmp_lo_q, new_hi_q, new_lo_q, rd_hi_q, rd_lo_q;
  logic              match_q, zf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      cmp_hi_q <= '0;
      cmp_lo_q <= '0;
      new_hi_q <= '0;
      new_lo_q <= '0;
      rd_hi_q  <= '0;
      rd_lo_q  <= '0;
      match_q  <= 1'b0;
      zf_q     <= 1'b0;
    end else begin
      if (cap_i) begin
        addr_q   <= addr_i;
        cmp_hi_q <= cmp_hi_i;
        cmp_lo_q <= cmp_lo_i;
        new_hi_q <= new_hi_i;
        new_lo_q <= new_lo_i;
      end
      if (rd_lo_en_i) rd_lo_q <= rdata_i;
      if (rd_hi_en_i) rd_hi_q <= rdata_i;
      if (cmp_en_i)   match_q <= ({rd_hi_q, rd_lo_q} == {cmp_hi_q, cmp_lo_q});
      if (fin_en_i) begin
        zf_q <= match_q;
        if (!match_q) begin
          cmp_hi_q <= rd_hi_q;
          cmp_lo_q <= rd_lo_q;
        end
      end
    end
  end

  // mismatch rewrites the value just read
  assign wr_lo_o  = match_q ? new_lo_q : rd_lo_q;
  assign wr_hi_o  = match_q ? new_hi_q : rd_hi_q;
  assign addr_o   = addr_q;
  assign cmp_hi_o = cmp_hi_q;
  assign cmp_lo_o = cmp_lo_q;
  assign zf_o     = zf_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !done_i) |-> ($stable(addr_q) && $stable(cmp_hi_q) && $stable(cmp_lo_q)));
  // R10
  zf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(zf_q));
  // R6
  miss_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !zf_q) |-> ({cmp_hi_q, cmp_lo_q} == {rd_hi_q, rd_lo_q}));
endmodule

// File: rtl/cas64_bus.sv
module cas64_bus #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              hi_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [HALF_W-1:0] wr_hi_i,
  input  logic [HALF_W-1:0] wr_lo_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [HALF_W-1:0] wdata_o
);
  localparam int unsigned STEP = HALF_W / 8;
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  assign addr_o  = hi_i ? (base_i + STEP_A) : base_i;
  assign wdata_o = hi_i ? wr_hi_i : wr_lo_i;
endmodule

// File: rtl/cas64_unit.sv
module cas64_unit #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] cmp_hi_i,
  input  logic [HALF_W-1:0] cmp_lo_i,
  input  logic [HALF_W-1:0] new_hi_i,
  input  logic [HALF_W-1:0] new_lo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              zf_o,
  output logic [HALF_W-1:0] cmp_hi_o,
  output logic [HALF_W-1:0] cmp_lo_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HALF_W-1:0] mem_wdata_o,
  input  logic [HALF_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              mem_lock_o
);
  logic hi, cap, rd_lo_en, rd_hi_en, cmp_en, fin_en;
  logic [ADDR_W-1:0] base;
  logic [HALF_W-1:0] wr_hi, wr_lo;

  cas64_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (mem_ack_i),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .hi_o       (hi),
    .lock_o     (mem_lock_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cap_o      (cap),
    .rd_lo_en_o (rd_lo_en),
    .rd_hi_en_o (rd_hi_en),
    .cmp_en_o   (cmp_en),
    .fin_en_o   (fin_en)
  );

  cas64_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .rd_lo_en_i (rd_lo_en),
    .rd_hi_en_i (rd_hi_en),
    .cmp_en_i   (cmp_en),
    .fin_en_i   (fin_en),
    .busy_i     (busy_o),
    .done_i     (done_o),
    .addr_i     (addr_i),
    .cmp_hi_i   (cmp_hi_i),
    .cmp_lo_i   (cmp_lo_i),
    .new_hi_i   (new_hi_i),
    .new_lo_i   (new_lo_i),
    .rdata_i    (mem_rdata_i),
    .addr_o     (base),
    .cmp_hi_o   (cmp_hi_o),
    .cmp_lo_o   (cmp_lo_o),
    .wr_hi_o    (wr_hi),
    .wr_lo_o    (wr_lo),
    .zf_o       (zf_o)
  );

  cas64_bus #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_bus (
    .hi_i    (hi),
    .base_i  (base),
    .wr_hi_i (wr_hi),
    .wr_lo_i (wr_lo),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );
endmodule

// File: tb/cas64_unit_tb_top.sv
module cas64_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] cmp_hi_i = '0, cmp_lo_i = '0, new_hi_i = '0, new_lo_i = '0;
  logic        busy_o, done_o, zf_o;
  logic [31:0] cmp_hi_o, cmp_lo_o;
  logic        mem_req_o, mem_we_o, mem_lock_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;

  cas64_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .cmp_hi_i(cmp_hi_i), .cmp_lo_i(cmp_lo_i), .new_hi_i(new_hi_i), .new_lo_i(new_lo_i),
    .busy_o(busy_o), .done_o(done_o), .zf_o(zf_o), .cmp_hi_o(cmp_hi_o), .cmp_lo_o(cmp_lo_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .mem_lock_o(mem_lock_o)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [16];
  int wait_n = 1;
  int cnt = 0;
  int acks_done = 0;
  int cyc = 0;
  bit in_op = 0;
  logic [31:0] q_addr[$];
  bit          q_we[$];
  logic [31:0] q_data[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic service();
    logic [31:0] ea, ed;
    bit ew;
    int idx;
    idx = int'(mem_addr_o[5:2]);
    if (q_addr.size() == 0) begin
      chk(1'b0, "R3 unexpected beat", 64'(mem_addr_o), 64'hFFFF_FFFF);
    end else begin
      ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_data.pop_front();
      chk(mem_addr_o == ea, "R3 beat address", 64'(mem_addr_o), 64'(ea));
      chk(mem_we_o == ew, "R3 beat direction", 64'(mem_we_o), 64'(ew));
      if (ew) chk(mem_wdata_o == ed, "R3 write data", 64'(mem_wdata_o), 64'(ed));
    end
    chk(mem_lock_o, "R4 lock during beat", 64'(mem_lock_o), 64'd1);
    if (mem_we_o) mem[idx] = mem_wdata_o;
    else          mem_rdata_i = mem[idx];
  endtask

  // memory model and per-clock reference comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        cnt = 0;
        acks_done++;
      end
      if (mem_req_o) begin
        if (cnt >= wait_n) begin
          mem_ack_i = 1'b1;
          service();
        end else cnt++;
      end
      if (in_op) begin
        cyc++;
        chk(busy_o, "R2 busy during op", 64'(busy_o), 64'd1);
        chk(mem_lock_o == (acks_done < 4), "R4 lock window", 64'(mem_lock_o), 64'(acks_done < 4));
        chk(done_o == (acks_done == 4), "R7 done timing", 64'(done_o), 64'(acks_done == 4));
        if (acks_done == 4) in_op = 0;
      end else begin
        chk(!busy_o && !done_o && !mem_lock_o && !mem_req_o, "R1 idle outputs",
            64'({busy_o, done_o, mem_lock_o, mem_req_o}), 64'd0);
      end
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] chi, input logic [31:0] clo,
                        input logic [31:0] nhi, input logic [31:0] nlo, input int w,
                        input bit intrude, input string tag);
    logic [31:0] rlo, rhi, ehi, elo;
    bit m;
    int idx;
    idx = int'(a[5:2]);
    rlo = mem[idx]; rhi = mem[idx+1];
    m = ({rhi, rlo} == {chi, clo});
    q_addr.push_back(a);     q_we.push_back(0); q_data.push_back(0);
    q_addr.push_back(a + 4); q_we.push_back(0); q_data.push_back(0);
    q_addr.push_back(a);     q_we.push_back(1); q_data.push_back(m ? nlo : rlo);
    q_addr.push_back(a + 4); q_we.push_back(1); q_data.push_back(m ? nhi : rhi);
    ehi = m ? chi : rhi; elo = m ? clo : rlo;
    wait_n = w; acks_done = 0; cyc = 0;
    addr_i = a; cmp_hi_i = chi; cmp_lo_i = clo; new_hi_i = nhi; new_lo_i = nlo; start_i = 1'b1;
    @(posedge clk_i);
    in_op = 1;
    @(negedge clk_i);
    start_i = 1'b0;
    addr_i = 32'h0000_0038; cmp_hi_i = ~chi; cmp_lo_i = ~clo; new_hi_i = 32'hDEAD_0000; new_lo_i = 32'h0000_BEEF;
    chk({cmp_hi_o, cmp_lo_o} == {chi, clo}, {"R2 captured expected ", tag}, {cmp_hi_o, cmp_lo_o}, {chi, clo});
    if (intrude) begin
      @(negedge clk_i);
      @(negedge clk_i);
      start_i = 1'b1; // R9 start while busy
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (!in_op);
    chk(cyc == 4 * (w + 1) + 2, {"R7 R8 latency ", tag}, 64'(cyc), 64'(4 * (w + 1) + 2));
    chk(zf_o == m, {"R5 R6 zero flag ", tag}, 64'(zf_o), 64'(m));
    chk({cmp_hi_o, cmp_lo_o} == {ehi, elo}, {"R5 R6 expected outputs ", tag}, {cmp_hi_o, cmp_lo_o}, {ehi, elo});
    @(negedge clk_i);
    chk(q_addr.size() == 0, {"R3 all beats ", tag}, 64'(q_addr.size()), 64'd0);
    chk({mem[idx+1], mem[idx]} == (m ? {nhi, nlo} : {rhi, rlo}), {"R5 R6 memory ", tag},
        {mem[idx+1], mem[idx]}, m ? {nhi, nlo} : {rhi, rlo});
    chk(!busy_o, {"R7 idle after done ", tag}, 64'(busy_o), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hz_hi, hz_lo;
    bit hz_zf;
    for (int i = 0; i < 16; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hC0DE_0000;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !zf_o && !mem_req_o && !mem_lock_o, "R1 reset controls",
        64'({busy_o, done_o, zf_o, mem_req_o, mem_lock_o}), 64'd0);
    chk({cmp_hi_o, cmp_lo_o} == 64'd0, "R1 reset expected outputs", {cmp_hi_o, cmp_lo_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({cmp_hi_o, cmp_lo_o, 31'd0, zf_o} == 96'd0, "R1 after reset", {cmp_hi_o, cmp_lo_o}, 64'd0);

    // R5 R7 match, one wait cycle, 10-cycle latency
    run_op(32'h08, mem[3], mem[2], 32'h1122_3344, 32'h5566_7788, 1, 0, "match");
    // R6 low-half mismatch, zero wait
    run_op(32'h10, mem[5], mem[4] ^ 32'h1, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0, "miss_lo");
    // R6 R8 high-half mismatch, three wait cycles
    run_op(32'h18, mem[7] ^ 32'h8000_0000, mem[6], 32'h0F0F_0F0F, 32'hF0F0_F0F0, 3, 0, "miss_hi");
    // R9 start pulse during operation
    run_op(32'h20, mem[9], mem[8], 32'h1357_9BDF, 32'h2468_ACE0, 1, 1, "intrude");
    // R9 mismatch with start during operation
    run_op(32'h28, mem[11], ~mem[10], 32'h0, 32'h0, 1, 1, "intrude_miss");
    // retry with returned value after a mismatch
    run_op(32'h28, cmp_hi_o, cmp_lo_o, 32'h7777_8888, 32'h9999_AAAA, 2, 0, "retry");

    // R10 outputs hold between operations
    hz_hi = cmp_hi_o; hz_lo = cmp_lo_o; hz_zf = zf_o;
    repeat (4) @(negedge clk_i);
    chk({cmp_hi_o, cmp_lo_o} == {hz_hi, hz_lo}, "R10 expected outputs hold", {cmp_hi_o, cmp_lo_o}, {hz_hi, hz_lo});
    chk(zf_o == hz_zf, "R10 zero flag holds", 64'(zf_o), 64'(hz_zf));
    run_op(32'h30, ~mem[13], mem[12], 32'h1, 32'h2, 0, 0, "miss_after");
    hz_hi = cmp_hi_o; hz_lo = cmp_lo_o;
    repeat (3) @(negedge clk_i);
    chk({cmp_hi_o, cmp_lo_o, 31'd0, zf_o} == {hz_hi, hz_lo, 32'd0}, "R10 hold after miss",
        {cmp_hi_o, cmp_lo_o}, {hz_hi, hz_lo});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule